// File: doc/BRIEF.md
# Sawtooth Pulse-Width Bridge Driver

This block turns a stream of short signed samples, delivered one per oversampled period, into a pulse-width-modulated bitstream for a full-bridge power stage. An internal counter acts as a digital sawtooth. It runs through all 2^SAMPLE_W codes once per sample period, so every possible input level has exactly one matching pulse width. The counter clock therefore has to run at 2^SAMPLE_W times the oversampled rate. For a 5-bit word at 48 kHz and an oversampling ratio of 25, that is 38.4 MHz. A wide word fed straight to a sawtooth would need an unreachable clock, which is why a noise-shaping quantizer upstream shortens the word before it reaches this block.

The upstream quantizer presents a word on `sample_i`. The block raises `sample_ready_o` for a single cycle in the last count of each sweep, and it takes the word on that edge only. The pulse width therefore never changes in the middle of a period. The word is read as two's complement and shifted to offset binary. The positive leg stays high while the counter is below that offset level. The negative leg is its complement. Both legs leave through registers, which feed a level shifter and the power switches outside this block. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `pwm_bridge_drive`

## Requirements
- R1: While `rst_ni` is low, and for the first two rising clock edges after it rises, `leg_pos_o`, `leg_neg_o` and `sample_ready_o` are all low.
- R2: Once reset has been released, the sawtooth steps through 2^SAMPLE_W codes in order and wraps to zero. `sample_ready_o` is high for exactly one cycle in every 2^SAMPLE_W. The first such cycle is the 2^SAMPLE_W-th cycle after the internal reset releases.
- R3: `sample_i` is taken only on the rising edge at the end of a cycle in which `sample_ready_o` is high. A change of `sample_i` in any other cycle has no effect on the pulse widths.
- R4: A taken word s, read as two's complement, sets the level L = s + 2^(SAMPLE_W-1). In the bit pattern this is the word with its top bit inverted. A word of zero gives half-scale duty.
- R5: In the period that follows the taking of a word, `leg_pos_o` is high for exactly L of the 2^SAMPLE_W cycles, and those are the first L cycles of the period. Because the leg is registered, each period on the legs starts one cycle after the counter passes zero.
- R6: After the first update out of reset, `leg_neg_o` is the complement of `leg_pos_o` in every cycle.
- R7: The most negative word (L = 0) keeps `leg_pos_o` low for the whole period. The most positive word (L = 2^SAMPLE_W - 1) leaves it low for exactly one cycle.
- R8: The first period after reset uses level 2^(SAMPLE_W-1), which gives 50% duty before any word has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sawtooth clock, 2^SAMPLE_W times the sample rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | SAMPLE_W | Signed two's-complement input word |
| sample_ready_o | output | 1 | One-cycle request; the word is taken at the end of this cycle |
| leg_pos_o | output | 1 | Positive bridge leg drive |
| leg_neg_o | output | 1 | Negative bridge leg drive, complement of the positive leg |

## Verification
The bench builds the block with SAMPLE_W = 4. This gives 16-cycle periods, so both extreme codes (-8 and +7), mid-scale and a spread of in-between levels all fit into a few hundred cycles. A behavioural model follows the synchronizer, the sweep and the one-cycle output register, and it is compared with the design on every cycle. The bench also counts the high cycles of the positive leg in each period and compares that count with the offset level. It drives arbitrary values on `sample_i` in every cycle outside the request strobe, which shows that only the strobed word reaches the pulse width.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Default word width after noise shaping.
  localparam int unsigned DEFAULT_SAMPLE_W = 5;

  // Registered drive for the two bridge legs.
  typedef struct packed {
    logic pos;
    logic neg;
  } bridge_legs_t;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_sweep_counter.sv
module pwm_sweep_counter #(
  parameter int unsigned SAMPLE_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  output logic [SAMPLE_W-1:0] count_o,
  output logic                wrap_o
);

  localparam logic [SAMPLE_W-1:0] LAST_CODE = {SAMPLE_W{1'b1}};

  logic [SAMPLE_W-1:0] count_q;
  logic [SAMPLE_W-1:0] count_d;
  logic                at_last;

  always_comb begin
    at_last = (count_q == LAST_CODE);
    count_d = count_q;
    if (en_i) begin
      if (at_last) begin
        count_d = '0;
      end else begin
        count_d = count_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = at_last & en_i;

endmodule

// File: rtl/pwm_sample_latch.sv
module pwm_sample_latch #(
  parameter int unsigned SAMPLE_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] level_o
);

  localparam logic [SAMPLE_W-1:0] HALF_SCALE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] level_q;
  logic [SAMPLE_W-1:0] level_d;
  logic [SAMPLE_W-1:0] offset_word;

  always_comb begin
    // Two's complement to offset binary: flip the sign bit.
    offset_word = sample_i ^ HALF_SCALE;
    level_d     = level_q;
    if (load_i) begin
      level_d = offset_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= HALF_SCALE;
    end else begin
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/pwm_leg_driver.sv
module pwm_leg_driver
  import pwm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] count_i,
  input  logic [SAMPLE_W-1:0] level_i,
  output logic                leg_pos_o,
  output logic                leg_neg_o
);

  bridge_legs_t legs_q;
  bridge_legs_t legs_d;
  logic         below;

  always_comb begin
    below  = (count_i < level_i);
    legs_d = legs_q;
    if (en_i) begin
      legs_d.pos = below;
      legs_d.neg = ~below;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      legs_q <= '0;
    end else begin
      legs_q <= legs_d;
    end
  end

  assign leg_pos_o = legs_q.pos;
  assign leg_neg_o = legs_q.neg;

endmodule

// File: rtl/pwm_bridge_drive.sv
module pwm_bridge_drive
  import pwm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEFAULT_SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sample_ready_o,
  output logic                leg_pos_o,
  output logic                leg_neg_o
);

  logic                rst_int_n;
  logic [SAMPLE_W-1:0] cnt_q;
  logic [SAMPLE_W-1:0] level_q;
  logic                wrap;
  logic                run_en;

  assign run_en = 1'b1;

  pwm_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_int_n)
  );

  pwm_sweep_counter #(
    .SAMPLE_W(SAMPLE_W)
  ) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (run_en),
    .count_o(cnt_q),
    .wrap_o (wrap)
  );

  pwm_sample_latch #(
    .SAMPLE_W(SAMPLE_W)
  ) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .load_i  (wrap),
    .sample_i(sample_i),
    .level_o (level_q)
  );

  pwm_leg_driver #(
    .SAMPLE_W(SAMPLE_W)
  ) u_legs (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .en_i     (run_en),
    .count_i  (cnt_q),
    .level_i  (level_q),
    .leg_pos_o(leg_pos_o),
    .leg_neg_o(leg_neg_o)
  );

  assign sample_ready_o = wrap & rst_int_n;

endmodule

// File: rtl/pwm_bridge_drive_chk.sv
module pwm_bridge_drive_chk #(
  parameter int unsigned SAMPLE_W = 5
) (
  input logic                clk_i,
  input logic                rst_int_n,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                sample_ready_o,
  input logic                leg_pos_o,
  input logic                leg_neg_o,
  input logic [SAMPLE_W-1:0] cnt_q,
  input logic [SAMPLE_W-1:0] level_q
);

  localparam logic [SAMPLE_W-1:0] TOP_CODE  = {SAMPLE_W{1'b1}};
  localparam logic [SAMPLE_W-1:0] SIGN_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // R2: the request strobe lasts a single cycle
  p_ready_single_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    sample_ready_o |=> !sample_ready_o);

  // R2: the sawtooth steps by one below the top code
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (cnt_q != TOP_CODE) |=> (cnt_q == SAMPLE_W'($past(cnt_q) + 1'b1)));

  // R2: the sawtooth returns to zero after the strobe
  p_count_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    sample_ready_o |=> (cnt_q == '0));

  // R3: the level holds outside the strobe cycle
  p_hold_level_r3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !sample_ready_o |=> $stable(level_q));

  // R4: the taken word appears as offset binary
  p_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    sample_ready_o |=> (level_q == ($past(sample_i) ^ SIGN_MASK)));

  // R6: legs are complementary once driven
  p_legs_compl_r6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    1'b1 |=> (leg_pos_o != leg_neg_o));

  // R7: a zero level never raises the positive leg
  p_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (level_q == '0) |=> !leg_pos_o);

endmodule

bind pwm_bridge_drive pwm_bridge_drive_chk #(
  .SAMPLE_W(SAMPLE_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_int_n     (rst_int_n),
  .sample_i      (sample_i),
  .sample_ready_o(sample_ready_o),
  .leg_pos_o     (leg_pos_o),
  .leg_neg_o     (leg_neg_o),
  .cnt_q         (cnt_q),
  .level_q       (level_q)
);

// File: tb/pwm_bridge_drive_tb_top.sv
`timescale 1ns/1ps
module pwm_bridge_drive_tb_top;

  localparam int W      = 4;
  localparam int STEPS  = 1 << W;
  localparam int HALF   = 1 << (W - 1);
  localparam int NWORDS = 13;
  localparam int RUN_CYCLES = 4 + 2 + STEPS * (NWORDS + 2);

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic         sample_ready_o;
  logic         leg_pos_o;
  logic         leg_neg_o;

  int checks = 0;
  int errors = 0;

  int words [NWORDS] = '{0, -8, 7, 3, -3, -1, 1, -8, 7, 5, -6, 2, 0};
  int widx = 0;

  // Behavioural model state
  int m_rs0 = 0, m_rs1 = 0, m_cnt = 0, m_lvl = HALF;
  int m_pos = 0, m_neg = 0, m_emit = 0, m_last = 0, m_wlvl = 0;
  int hi_acc = 0, win_no = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_bridge_drive #(.SAMPLE_W(W)) dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sample_i      (sample_i),
    .sample_ready_o(sample_ready_o),
    .leg_pos_o     (leg_pos_o),
    .leg_neg_o     (leg_neg_o)
  );

  always @(posedge clk_i) begin
    int old_rs0, old_rs1, sv;
    if (!rst_ni) begin
      m_rs0 = 0; m_rs1 = 0; m_cnt = 0; m_lvl = HALF;
      m_pos = 0; m_neg = 0; m_emit = 0; m_last = 0;
    end else begin
      old_rs0 = m_rs0; old_rs1 = m_rs1;
      m_rs0 = 1; m_rs1 = old_rs0;
      m_emit = 0; m_last = 0;
      if (old_rs1 != 0) begin
        m_pos  = (m_cnt < m_lvl) ? 1 : 0;
        m_neg  = 1 - m_pos;
        m_emit = 1;
        m_wlvl = m_lvl;
        if (m_cnt == STEPS - 1) begin
          m_last = 1;
          sv = $signed(sample_i);
          m_lvl = sv + HALF;
          m_cnt = 0;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_cycle();
    int exp_rdy;
    exp_rdy = (m_rs1 != 0 && m_cnt == STEPS - 1) ? 1 : 0;
    check(sample_ready_o == exp_rdy[0], "R2 ready strobe", sample_ready_o, exp_rdy);
    check(leg_pos_o == m_pos[0], "R5 positive leg", leg_pos_o, m_pos);
    check(leg_neg_o == m_neg[0], "R6 negative leg", leg_neg_o, m_neg);
    if (m_emit != 0) hi_acc += leg_pos_o;
    if (m_last != 0) begin
      if (win_no == 0)
        check(hi_acc == HALF, "R8 first period half scale", hi_acc, HALF);
      else if (m_wlvl == 0)
        check(hi_acc == 0, "R7 floor level", hi_acc, 0);
      else if (m_wlvl == STEPS - 1)
        check(hi_acc == STEPS - 1, "R7 top level", hi_acc, STEPS - 1);
      else
        check(hi_acc == m_wlvl, "R4 R3 period width", hi_acc, m_wlvl);
      hi_acc = 0;
      win_no++;
    end
  endtask

  initial begin
    // R1: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check(!leg_pos_o && !leg_neg_o, "R1 legs in reset", {leg_pos_o, leg_neg_o}, 0);
      check(!sample_ready_o, "R1 ready in reset", sample_ready_o, 0);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < RUN_CYCLES; i++) begin
      @(negedge clk_i);
      if (i < 2)
        check(!leg_pos_o && !leg_neg_o && !sample_ready_o, "R1 sync release",
              {leg_pos_o, leg_neg_o, sample_ready_o}, 0);
      compare_cycle();
      if (sample_ready_o) begin
        sample_i = (widx < NWORDS) ? W'(words[widx]) : '0;
        widx++;
      end else begin
        // R3: arbitrary values outside the strobe
        sample_i = W'($urandom);
      end
    end
    check(win_no >= NWORDS, "R2 period count", win_no, NWORDS);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule